// File: doc/BRIEF.md
# Waveform-Cycle Coherent Averager

This block averages a sampled signal coherently across repeated excitation waveform cycles. It sits after the sample stream and before the spectral transform. Each waveform cycle yields a record of `REC_LEN` samples, and the first sample of each record is flagged by a cycle-start marker that is aligned to the excitation trigger. The block keeps one running sum for each sample position in the record. Across a group of K successive cycles it adds the sample at a given position to that position's sum. While the K-th cycle arrives, it emits the averaged record one sample at a time.

K is a power of two from 1 to 64 and is set as log2(K) on a configuration input. Normalisation is therefore an arithmetic right shift. The first cycle of each group overwrites the stored sums, so data from an earlier group never carries over. The accumulator is 6 bits wider than a sample, which means a sum over 64 cycles cannot overflow. With K = 1 the averaged stream equals the input stream, delayed by one cycle.

Top module: `coh_avg`

## Requirements
- R1: A valid sample that carries `cyc_start_i` is record position 0, and each later valid sample takes the next position up to `REC_LEN-1`. Valid samples that arrive before the first cycle start after reset are ignored. Valid samples beyond position `REC_LEN-1` that arrive before the next cycle start are also ignored.
- R2: K = 2^`cfg_log2k_i`. Any setting above 6 is treated as 6, so K = 64.
- R3: K is captured on the cycle start that opens a group. Changing `cfg_log2k_i` during a group has no effect until the next group opens.
- R4: During the K-th cycle of a group, the output for position p equals the signed sum of the K samples at position p shifted right arithmetically by log2(K), which is the floor of the mean. It appears on `avg_o` with `avg_valid_o` high exactly one clock after that position's sample is accepted. This holds at full-scale positive and full-scale negative input.
- R5: No output is produced during cycles 1 to K-1 of a group.
- R6: The first cycle of each group replaces the stored sums. A group's averages depend only on that group's samples.
- R7: With K = 1, `avg_o` reproduces each accepted sample one clock later.
- R8: `avg_last_o` is high together with `avg_valid_o` exactly on the output for position `REC_LEN-1`.
- R9: While `rst_ni` is low, and after it is released, `avg_valid_o` and `avg_last_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_log2k_i | input | 3 | log2 of the averaging factor K |
| smp_i | input | DATA_W | Signed input sample |
| smp_valid_i | input | 1 | Input sample valid |
| cyc_start_i | input | 1 | Marks the first sample of a waveform cycle |
| avg_o | output | DATA_W | Averaged sample |
| avg_valid_o | output | 1 | Averaged sample valid |
| avg_last_o | output | 1 | Averaged sample is the last position of the record |

## Verification
When groups are streamed back to back, two functions fall in the same clock cycle. The averaged output for the last position of one group is emitted in the same cycle that the first sample of the next group is written into the accumulator as a fresh overwrite. The bench provokes this by sending two K = 2 groups with no idle cycle between them and then comparing every emitted value against sums computed in the bench. It also checks the emission cycle of every output, so a clobbered sum or a shifted emission in the second group shows up as a value or timing mismatch.

// File: rtl/coh_avg_pkg.sv
package coh_avg_pkg;
  localparam int unsigned MAX_LOG_K = 6;
  localparam int unsigned LOG_W     = $clog2(MAX_LOG_K + 1);

  function automatic logic [LOG_W-1:0] clamp_log(input logic [LOG_W-1:0] v);
    return (v > LOG_W'(MAX_LOG_K)) ? LOG_W'(MAX_LOG_K) : v;
  endfunction

  function automatic logic [MAX_LOG_K-1:0] cyc_mask(input logic [LOG_W-1:0] l);
    return MAX_LOG_K'((1 << l) - 1);
  endfunction
endpackage

// File: rtl/coh_avg_seq.sv
module coh_avg_seq
  import coh_avg_pkg::*;
#(
  parameter int unsigned REC_LEN = 512
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 start_i,
  input  logic [LOG_W-1:0]     cfg_i,
  output logic                 take_o,
  output logic [$clog2(REC_LEN)-1:0] pos_o,
  output logic                 first_o,
  output logic                 final_o,
  output logic [LOG_W-1:0]     klog_o
);
  localparam int unsigned PW = $clog2(REC_LEN);
  localparam logic [PW-1:0] LAST = PW'(REC_LEN - 1);

  logic                 armed_q, open_q;
  logic [PW-1:0]        pos_q, pos_n;
  logic [MAX_LOG_K-1:0] cyc_q, cyc_n;
  logic [LOG_W-1:0]     klog_q, klog_n;
  logic                 new_grp;

  always_comb begin
    new_grp = start_i & (~armed_q | (cyc_q == cyc_mask(klog_q)));
    take_o  = valid_i & (start_i | (open_q & (pos_q != LAST)));
    pos_n   = start_i ? '0 : pos_q + 1'b1;
    cyc_n   = start_i ? (new_grp ? '0 : cyc_q + 1'b1) : cyc_q;
    klog_n  = new_grp ? clamp_log(cfg_i) : klog_q;
    pos_o   = pos_n;
    klog_o  = klog_n;
    first_o = (cyc_n == '0);
    final_o = (cyc_n == cyc_mask(klog_n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      open_q  <= 1'b0;
      pos_q   <= '0;
      cyc_q   <= '0;
      klog_q  <= '0;
    end else if (take_o) begin
      armed_q <= 1'b1;
      open_q  <= (pos_n != LAST);
      pos_q   <= pos_n;
      cyc_q   <= cyc_n;
      klog_q  <= klog_n;
    end
  end

  assert_klog_clamped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    klog_q <= LOG_W'(MAX_LOG_K));

  assert_cyc_in_group_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= cyc_mask(klog_q));

  assert_idle_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> ($stable(pos_q) && $stable(cyc_q) && $stable(klog_q)));
endmodule

// File: rtl/coh_avg_acc.sv
module coh_avg_acc #(
  parameter int unsigned REC_LEN = 512,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ACC_W   = 22
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [$clog2(REC_LEN)-1:0] addr_i,
  input  logic                       first_i,
  input  logic signed [DATA_W-1:0]   smp_i,
  output logic signed [ACC_W-1:0]    sum_o
);
  logic signed [ACC_W-1:0] mem [REC_LEN];
  logic signed [ACC_W-1:0] ext;

  always_comb begin
    ext   = ACC_W'(smp_i);
    // first cycle of a group overwrites the stale sum
    sum_o = first_i ? ext : mem[addr_i] + ext;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= sum_o;
  end
endmodule

// File: rtl/coh_avg_norm.sv
module coh_avg_norm
  import coh_avg_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 22
) (
  input  logic signed [ACC_W-1:0]  sum_i,
  input  logic [LOG_W-1:0]         klog_i,
  output logic signed [DATA_W-1:0] avg_o
);
  logic signed [DATA_W-1:0] cand [MAX_LOG_K+1];

  for (genvar g = 0; g <= MAX_LOG_K; g++) begin : g_shift
    logic signed [ACC_W-1:0] sh;
    assign sh      = sum_i >>> g;
    assign cand[g] = sh[DATA_W-1:0];
  end

  always_comb begin
    avg_o = cand[0];
    for (int i = 1; i <= MAX_LOG_K; i++)
      if (klog_i == LOG_W'(i)) avg_o = cand[i];
  end
endmodule

// File: rtl/coh_avg.sv
module coh_avg
  import coh_avg_pkg::*;
#(
  parameter int unsigned REC_LEN = 512,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LOG_W-1:0]         cfg_log2k_i,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic                     smp_valid_i,
  input  logic                     cyc_start_i,
  output logic signed [DATA_W-1:0] avg_o,
  output logic                     avg_valid_o,
  output logic                     avg_last_o
);
  localparam int unsigned ACC_W = DATA_W + MAX_LOG_K;
  localparam int unsigned PW    = $clog2(REC_LEN);

  logic                     take, first, final_c;
  logic [PW-1:0]            pos;
  logic [LOG_W-1:0]         klog;
  logic signed [ACC_W-1:0]  sum;
  logic signed [DATA_W-1:0] avg_c;

  coh_avg_seq #(.REC_LEN(REC_LEN)) u_seq (
    .clk_i, .rst_ni,
    .valid_i (smp_valid_i),
    .start_i (cyc_start_i),
    .cfg_i   (cfg_log2k_i),
    .take_o  (take),
    .pos_o   (pos),
    .first_o (first),
    .final_o (final_c),
    .klog_o  (klog)
  );

  coh_avg_acc #(.REC_LEN(REC_LEN), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk_i,
    .we_i    (take),
    .addr_i  (pos),
    .first_i (first),
    .smp_i   (smp_i),
    .sum_o   (sum)
  );

  coh_avg_norm #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_norm (
    .sum_i  (sum),
    .klog_i (klog),
    .avg_o  (avg_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_o       <= '0;
      avg_valid_o <= 1'b0;
      avg_last_o  <= 1'b0;
    end else begin
      avg_valid_o <= take & final_c;
      avg_last_o  <= take & final_c & (pos == PW'(REC_LEN - 1));
      if (take & final_c) avg_o <= avg_c;
    end
  end

  assert_last_with_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_last_o |-> avg_valid_o);

  assert_out_after_input_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_valid_o |-> $past(smp_valid_i));

  assert_quiet_mid_group_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !final_c) |=> !avg_valid_o);

  assert_k1_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && first && final_c) |=> (avg_valid_o && avg_o == $past(smp_i)));
endmodule

// File: tb/coh_avg_tb.sv
`timescale 1ns/1ps
module coh_avg_tb;
  localparam int L  = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg = '0;
  logic signed [DW-1:0] smp = '0;
  logic vld = 1'b0, start = 1'b0;
  logic signed [DW-1:0] avg;
  logic avg_vld, avg_last;

  always #5 clk = ~clk;

  coh_avg #(.REC_LEN(L), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_log2k_i(cfg), .smp_i(smp),
    .smp_valid_i(vld), .cyc_start_i(start),
    .avg_o(avg), .avg_valid_o(avg_vld), .avg_last_o(avg_last)
  );

  int total = 0, bad = 0;
  int cyc_cnt = 0;
  int cap_n = 0, exp_n = 0;
  int cap_val [256];
  int cap_last[256];
  int cap_cyc [256];
  int exp_val [256];
  int exp_last[256];
  int exp_cyc [256];

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  always @(negedge clk) begin
    if (avg_vld && cap_n < 256) begin
      cap_val[cap_n]  = int'(avg);
      cap_last[cap_n] = int'(avg_last);
      cap_cyc[cap_n]  = cyc_cnt;
      cap_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int v, input bit s, output int at);
    @(negedge clk);
    smp = DW'(v); vld = 1'b1; start = s;
    at = cyc_cnt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0; start = 1'b0;
    end
  endtask

  function automatic int gen(input int mode, input int c, input int p, input int seed);
    case (mode)
      1: return 32767;
      2: return -32768;
      3: return ((c % 2) ? 30000 : -30000) + p;
      default: return ((c * 37 + p * 101 + seed * 13) % 4001) - 2000;
    endcase
  endfunction

  // sends keff cycles; cfg_a at group open, cfg_b for later cycles
  task automatic send_group(input int cfg_a, input int cfg_b, input int keff, input int seed,
                            input int gap, input int mode, input int extra);
    int acc [L];
    int at, lg;
    lg = $clog2(keff);
    for (int p = 0; p < L; p++) acc[p] = 0;
    for (int c = 0; c < keff; c++) begin
      for (int p = 0; p < L; p++) begin
        int v;
        v = gen(mode, c, p, seed);
        acc[p] += v;
        if (p == 0) cfg = 3'((c == 0) ? cfg_a : cfg_b);
        drive(v, p == 0, at);
        if (c == keff - 1) begin
          exp_val[exp_n]  = acc[p] >>> lg;
          exp_last[exp_n] = (p == L - 1);
          exp_cyc[exp_n]  = at + 1;
          exp_n++;
        end
        if (gap > 0 && (p % 3) == 1) idle(gap);
      end
      for (int e = 0; e < extra; e++) drive(12345, 1'b0, at);
    end
  endtask

  task automatic check_out(input string req);
    int n;
    idle(4);
    chk(req, "output count", cap_n, exp_n);
    n = (cap_n < exp_n) ? cap_n : exp_n;
    for (int i = 0; i < n; i++) begin
      chk(req, "avg value", cap_val[i], exp_val[i]);
      chk("R8", "last flag", cap_last[i], exp_last[i]);
      chk("R4", "emit cycle", cap_cyc[i], exp_cyc[i]);
    end
    cap_n = 0; exp_n = 0;
  endtask

  task automatic t_reset;
    int at;
    idle(2);
    chk("R9", "valid in reset", int'(avg_vld), 0);
    chk("R9", "last in reset", int'(avg_last), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R9", "valid after reset", int'(avg_vld), 0);
    chk("R9", "last after reset", int'(avg_last), 0);
    // R1: samples before the first cycle start are ignored
    cfg = 3'd0;
    for (int i = 0; i < 5; i++) drive(777, 1'b0, at);
    idle(3);
    chk("R1", "output before first start", cap_n, 0);
  endtask

  task automatic t_passthru;   // R7
    send_group(0, 0, 1, 3, 0, 0, 0);
    check_out("R7");
  endtask

  task automatic t_k4;         // R4 R5 with gaps
    send_group(2, 2, 4, 5, 2, 0, 0);
    check_out("R4");
  endtask

  task automatic t_full_scale; // R4 boundaries at K=64
    send_group(6, 6, 64, 0, 0, 1, 0);
    check_out("R4");
    send_group(6, 6, 64, 0, 0, 2, 0);
    check_out("R4");
  endtask

  task automatic t_clamp;      // R2: setting 7 acts as 64
    send_group(7, 7, 64, 9, 0, 3, 0);
    check_out("R2");
  endtask

  task automatic t_cfg_mid;    // R3: change after group opens
    send_group(2, 0, 4, 11, 0, 0, 0);
    check_out("R3");
  endtask

  task automatic t_overwrite;  // R6: new group ignores old sums
    send_group(1, 1, 2, 0, 0, 1, 0);
    check_out("R6");
    send_group(1, 1, 2, 17, 0, 0, 0);
    check_out("R6");
  endtask

  task automatic t_overrun;    // R1: samples past record end ignored
    send_group(1, 1, 2, 21, 0, 0, 3);
    check_out("R1");
  endtask

  task automatic t_back2back;  // emit last while next group overwrites
    send_group(1, 1, 2, 23, 0, 0, 0);
    send_group(1, 1, 2, 29, 0, 3, 0);
    check_out("R6");
  endtask

  initial begin
    t_reset();
    t_passthru();
    t_k4();
    t_full_scale();
    t_clamp();
    t_cfg_mid();
    t_overwrite();
    t_overrun();
    t_back2back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule